// File: doc/BRIEF.md
# Rate-1/2 Streaming Convolutional Encoder with Zero Tail

This block encodes a serial message stream with a rate-1/2 convolutional code of constraint length 3. Each accepted information bit is combined with the two bits held in the encoder memory. Two modulo-2 adder trees then form a two-bit branch word. That word leaves the block one bit per transfer on a valid/ready output, the first coded bit before the second. Message bits enter through a valid/ready input that carries a last-bit marker.

When the last message bit of a frame has been accepted, the block inserts zero tail bits by itself, as many as the memory is deep. The encoder memory therefore returns to all-zero at the end of every frame. The final coded bit of the tail carries an end-of-frame marker. The generator taps and the constraint length are parameters. The defaults give taps 111 and 101 at constraint length 3.

Top module: `conv_tail_encoder`

## Requirements
- R1: Each accepted input bit produces exactly one branch word of two coded bits. The bits leave on `out_bit`, one per cycle in which `out_valid` and `out_ready` are both high, with coded bit u1 sent before u2.
- R2: u1 is the XOR of the newest input bit and both memory bits (taps 111).
- R3: u2 is the XOR of the newest input bit and the oldest memory bit. The middle stage is skipped (taps 101).
- R4: From reset the memory is 00. For the message 1,0,1 the complete coded stream is 11 10 00 10 11, in transfer order.
- R5: After a bit accepted with `in_last` high, the block runs two extra steps with input 0 and no input handshake, and sends their branch words.
- R6: `out_eof` is high only on the final coded bit of the second tail word. At that point the memory is back at 00, so the next frame encodes from 00.
- R7: `in_ready` is high exactly when no coded bit is pending, or when only the final bit of the current word is pending and `out_ready` is high. It is low whenever tail steps remain.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` hold in the next cycle and the memory does not change.
- R9: A synchronous active-high `rst` clears the memory to 00, drops any partly sent word and any pending tail steps, and holds `out_valid` low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message bit offered |
| in_bit | input | 1 | Message bit value |
| in_last | input | 1 | Offered bit is the last of its frame |
| in_ready | output | 1 | Encoder takes the offered bit this cycle |
| out_valid | output | 1 | Coded bit available |
| out_bit | output | 1 | Coded bit value |
| out_eof | output | 1 | This coded bit closes the frame |
| out_ready | input | 1 | Receiver takes the coded bit this cycle |

## Verification
An accepted input bit loads its branch word at that same edge. Its u1 therefore appears on `out_bit` in the next cycle, and u2 appears in the cycle after the u1 transfer. Each tail word loads at the edge on which the previous word's final bit transfers. The bench drives inputs and samples one time unit after each falling edge. It records every handshake for the coming rising edge in a queue of expected bits built by a tap-by-tap reference encoder. Each transfer is compared with the head of that queue. The exact `in_ready` value and the hold behaviour under a stalled output are derived from the queue depth in the same cycle.

// File: rtl/conv_pkg.sv
package conv_pkg;

    localparam int unsigned CONSTR_LEN_DEF = 3;
    localparam int unsigned CODED_BITS_DEF = 2;

    // One encoder step as seen by the serializer.
    typedef struct packed {
        logic data;      // bit shifted into the window
        logic frame_end; // step is the final tail step
    } step_req_t;

    function automatic logic tap_parity(input logic [31:0] win, input logic [31:0] taps);
        logic acc;
        acc = 1'b0;
        for (int s = 0; s < 32; s++) begin
            acc = acc ^ (win[s] & taps[s]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/conv_state.sv
module conv_state #(
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         step_bit,
    input  logic         arm_tail,
    output logic [K-1:0] window,
    output logic [K-2:0] mem,
    output logic         tail_pending,
    output logic         tail_final
);
    localparam int TW = $clog2(K) + 1;

    logic [TW-1:0] tail_cnt;

    // window[K-1] is the newest stage, window[0] the oldest
    assign window       = {step_bit, mem};
    assign tail_pending = (tail_cnt != '0);
    assign tail_final   = (tail_cnt == TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mem      <= '0;
            tail_cnt <= '0;
        end else if (step) begin
            mem <= window[K-1:1];
            if (arm_tail) begin
                tail_cnt <= TW'(K - 1);
            end else if (tail_pending) begin
                tail_cnt <= tail_cnt - TW'(1);
            end
        end
    end

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(mem));

endmodule

// File: rtl/conv_adders.sv
module conv_adders #(
    parameter int K = 3,
    parameter int NOUT = 2,
    parameter logic [NOUT*K-1:0] GENS = 6'b101_111
) (
    input  logic [K-1:0]    window,
    output logic [NOUT-1:0] word
);
    import conv_pkg::*;

    for (genvar j = 0; j < NOUT; j++) begin : g_tree
        // R2 R3: one modulo-2 adder tree per generator
        assign word[j] = tap_parity(32'(window), 32'(GENS[j*K +: K]));
    end

endmodule

// File: rtl/conv_serial.sv
module conv_serial #(
    parameter int NOUT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [NOUT-1:0] word_in,
    input  logic            eof_in,
    input  logic            out_ready,
    output logic            out_valid,
    output logic            out_bit,
    output logic            out_eof,
    output logic            free
);
    localparam int IW = (NOUT > 1) ? $clog2(NOUT) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NOUT - 1);

    logic [NOUT-1:0] word_q;
    logic [IW-1:0]   idx_q;
    logic            eof_q;
    logic            vld_q;

    assign out_valid = vld_q;
    assign out_bit   = word_q[idx_q];
    assign out_eof   = vld_q && eof_q && (idx_q == LAST_IDX);
    assign free      = !vld_q || ((idx_q == LAST_IDX) && out_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
            eof_q  <= 1'b0;
            vld_q  <= 1'b0;
        end else if (load) begin
            word_q <= word_in;
            eof_q  <= eof_in;
            idx_q  <= '0;
            vld_q  <= 1'b1;
        end else if (vld_q && out_ready) begin
            if (idx_q == LAST_IDX) begin
                vld_q <= 1'b0;
            end else begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: rtl/conv_tail_encoder.sv
module conv_tail_encoder #(
    parameter int K = conv_pkg::CONSTR_LEN_DEF,
    parameter int NOUT = conv_pkg::CODED_BITS_DEF,
    parameter logic [NOUT*K-1:0] GENS = 6'b101_111
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    input  logic in_last,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    output logic out_eof,
    input  logic out_ready
);
    import conv_pkg::*;

    logic            ser_free;
    logic            tail_pending;
    logic            tail_final;
    logic            step_fire;
    logic            arm_tail;
    step_req_t       req;
    logic [K-1:0]    window;
    logic [K-2:0]    mem;
    logic [NOUT-1:0] word;

    assign in_ready      = ser_free && !tail_pending;
    assign step_fire     = ser_free && (tail_pending || in_valid);
    assign arm_tail      = in_ready && in_valid && in_last;
    assign req.data      = tail_pending ? 1'b0 : in_bit;
    assign req.frame_end = tail_pending && tail_final;

    conv_state #(.K(K)) u_state (
        .clk          (clk),
        .rst          (rst),
        .step         (step_fire),
        .step_bit     (req.data),
        .arm_tail     (arm_tail),
        .window       (window),
        .mem          (mem),
        .tail_pending (tail_pending),
        .tail_final   (tail_final)
    );

    conv_adders #(.K(K), .NOUT(NOUT), .GENS(GENS)) u_adders (
        .window (window),
        .word   (word)
    );

    conv_serial #(.NOUT(NOUT)) u_serial (
        .clk       (clk),
        .rst       (rst),
        .load      (step_fire),
        .word_in   (word),
        .eof_in    (req.frame_end),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_eof   (out_eof),
        .free      (ser_free)
    );

    // R7
    tail_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
        tail_pending |-> !in_ready);

    // R6
    eof_state_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> (mem == '0));

    // R5
    tail_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> tail_pending);

endmodule

// File: tb/test_conv_tail_encoder.sv
module test_conv_tail_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int K = 3;
    localparam int NOUT = 2;
    localparam logic [NOUT*K-1:0] GENS = 6'b101_111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid, out_bit, out_eof;

    int checks = 0;
    int fails = 0;
    logic [1:0]   exp_q[$];
    logic [K-2:0] ref_mem;
    logic         stall_prev = 1'b0;
    logic         stall_bit = 1'b0;
    logic [31:0]  got = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_tail_encoder #(.K(K), .NOUT(NOUT), .GENS(GENS)) i_conv_tail_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .in_last(in_last),
        .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit), .out_eof(out_eof),
        .out_ready(out_ready)
    );

    function automatic logic [NOUT-1:0] ref_word(input logic b, input logic [K-2:0] m);
        logic [K-1:0]    w;
        logic [NOUT-1:0] r;
        w = {b, m};
        for (int j = 0; j < NOUT; j++) begin
            r[j] = 1'b0;
            for (int s = 0; s < K; s++) r[j] = r[j] ^ (GENS[j*K+s] & w[s]);
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic push_step(input logic b, input logic last_word);
        logic [NOUT-1:0] wd;
        logic [K-1:0]    w;
        wd = ref_word(b, ref_mem);
        w = {b, ref_mem};
        ref_mem = w[K-1:1];
        for (int j = 0; j < NOUT; j++)
            exp_q.push_back({last_word && (j == NOUT-1), wd[j]});
    endtask

    task automatic cyc(input logic iv, input logic ib, input logic il, input logic ordy,
                       output logic acc);
        logic       exp_rdy;
        logic [1:0] e;
        in_valid = iv; in_bit = ib; in_last = il; out_ready = ordy;
        #1;
        if (stall_prev)
            chk(out_valid === 1'b1 && out_bit === stall_bit, "R8 hold under stall",
                int'(out_bit), int'(stall_bit));
        chk(out_valid === (exp_q.size() != 0), "R1 out_valid", int'(out_valid),
            int'(exp_q.size() != 0));
        exp_rdy = (exp_q.size() == 0) || (exp_q.size() == 1 && ordy);
        chk(in_ready === exp_rdy, "R7 in_ready", int'(in_ready), int'(exp_rdy));
        if (out_valid && ordy && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(out_bit === e[0], "R2 R3 R5 coded bit", int'(out_bit), int'(e[0]));
            chk(out_eof === e[1], "R6 eof marker", int'(out_eof), int'(e[1]));
            got = {got[30:0], out_bit};
        end
        acc = iv && in_ready;
        if (acc) begin
            push_step(ib, 1'b0);
            if (il) begin
                for (int t = 0; t < K-1; t++) push_step(1'b0, t == K-2);
            end
        end
        stall_prev = out_valid && !ordy;
        stall_bit = out_bit;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        ref_mem = '0;
        stall_prev = 1'b0;
        #1;
        chk(out_valid === 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        chk(in_ready === 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic drain();
        logic a;
        for (int g = 0; g < 200 && exp_q.size() > 0; g++) cyc(1'b0, 1'b0, 1'b0, 1'b1, a);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, a);
    endtask

    task automatic send_frame(input int len, input logic [31:0] bits, input int vpct,
                              input int rpct);
        logic a;
        int   i;
        i = 0;
        while (i < len) begin
            cyc(($urandom % 100) < vpct, bits[i], i == len-1, ($urandom % 100) < rpct, a);
            if (a) i++;
        end
    endtask

    initial begin
        logic a;
        void'($urandom(32'h5eed_0c0d));
        ref_mem = '0;
        @(negedge clk);
        do_reset();

        // R4: directed message 1,0,1 with the output always ready
        got = '0;
        send_frame(3, 32'b101, 100, 100);
        drain();
        chk(got[9:0] === 10'b11_10_00_10_11, "R4 stream for 101", int'(got[9:0]),
            int'(10'b11_10_00_10_11));

        // R8: output stalled while input offered
        for (int c = 0; c < 3; c++) cyc(1'b1, 1'b1, 1'b0, 1'b1, a);
        for (int c = 0; c < 6; c++) cyc(1'b1, 1'b0, 1'b0, 1'b0, a);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, a);
        drain();

        // single-bit frames back to back, R5 R6
        for (int f = 0; f < 4; f++) send_frame(1, 32'(f & 1), 100, 100);
        drain();

        // random frames
        for (int f = 0; f < 60; f++) begin
            send_frame(1 + ($urandom % 12), $urandom, 70, 65);
        end
        drain();

        // R9: reset in the middle of a frame and its tail
        for (int c = 0; c < 4; c++) cyc(1'b1, 1'b1, c == 3, 1'b0, a);
        do_reset();
        send_frame(5, 32'b10110, 80, 80);
        drain();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule